// File: doc/BRIEF.md
# Test Access Port Controller with Routed User and Configuration Scan Ports

This block is the serial test controller of a chip: a 16-state test-mode state machine clocked by the test clock and steered by the mode-select line, a 5-bit instruction register, and a data-register selector between the serial input and the serial output. Built-in data registers are a 1-bit bypass stage and a 32-bit device identifier. Five external scan ports hang off the same serial path: the boundary chain (one chain through every I/O cell, bonded or not), two user-defined scan registers, a configuration readback path and a configuration write path.

Each external port gets its own capture, shift and update strobes and returns one serial bit. The serial input is passed to all ports on a shared line. Only the port chosen by the current instruction sees strobes, and only that port's return bit reaches the serial output. Two static outputs tell the I/O ring to drive the boundary chain's values onto the pins or to put every pin into high impedance.

Top module: `tap_ctrl`

States, all reached on the rising test clock edge: RESET (TMS=1 stays, 0 goes to IDLE), IDLE (1 to DR_SELECT), DR_SELECT (0 to DR_CAPTURE, 1 to IR_SELECT), DR_CAPTURE (0 to DR_SHIFT, 1 to DR_EXIT1), DR_SHIFT (1 to DR_EXIT1), DR_EXIT1 (0 to DR_PAUSE, 1 to DR_UPDATE), DR_PAUSE (1 to DR_EXIT2), DR_EXIT2 (0 to DR_SHIFT, 1 to DR_UPDATE), DR_UPDATE (0 to IDLE, 1 to DR_SELECT); the IR_ states follow the same pattern, except IR_SELECT goes to RESET on 1. With the other TMS value, a state stays where it is (IDLE, DR_SHIFT, DR_PAUSE, IR_SHIFT, IR_PAUSE).

## Requirements
- R1: An asynchronous low on `trst_n` puts the controller in RESET. Five consecutive rising edges with `tms` high reach RESET from any state.
- R2: State transitions follow the table above. In particular a DR_PAUSE detour (EXIT1, PAUSE, PAUSE, EXIT2, SHIFT) keeps the shifted data intact.
- R3: In RESET the instruction becomes IDCODE (01001). The identifier register captures `ID_CODE` in DR_CAPTURE and shifts it out least significant bit first.
- R4: In IR_CAPTURE the instruction shift register loads 00001, so the two bits shifted out first are 1 then 0. The instruction is shifted in least significant bit first.
- R5: The instruction changes only on the rising edge that leaves IR_UPDATE, or in RESET. Opcode map: 00000 boundary drive, 00001 boundary sample, 00010 user scan 1, 00011 user scan 2, 00100 configuration readback, 00101 configuration write, 00111 pins high impedance, 01001 IDCODE, 11111 BYPASS. Every other opcode acts as BYPASS.
- R6: The bypass register is one bit. It captures 0 and delays the serial input by one shift.
- R7: Port index mapping: 0 boundary (00000, 00001), 1 user 1, 2 user 2, 3 readback, 4 configuration write. Only the selected port's bit in `ext_capture`, `ext_shift` or `ext_update` asserts, during DR_CAPTURE, DR_SHIFT or DR_UPDATE respectively, and its `ext_tdo` bit is what is shifted out.
- R8: `bsr_drive` is high exactly while opcode 00000 is current. `highz` is high exactly while 00111 is current, and that opcode shifts through the bypass register.
- R9: `tdo_oe` is high only in DR_SHIFT and IR_SHIFT. `tdo` and `tdo_oe` change on the falling test clock edge, and `tdi` is sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| scan_si | output | 1 | Serial input shared by all external ports |
| ext_tdo | input | 5 | Serial return bit of each external port |
| ext_capture | output | 5 | Per-port capture strobe |
| ext_shift | output | 5 | Per-port shift strobe |
| ext_update | output | 5 | Per-port update strobe |
| bsr_drive | output | 1 | Boundary chain values drive the pins |
| highz | output | 1 | All pins forced to high impedance |

## Verification
All 32 opcodes are swept. For each one a 4-bit data scan with pattern 1010 is run while the five port return bits are held at the distinct levels 1,0,1,1,0. The shifted-out value and the per-port strobe counts then separate the identifier, bypass (0100) and each of the five ports. A 32-bit identifier scan is split by a pause detour to show that the shift data is retained. Five-high escapes from a data shift and an asynchronous reset in the middle of a user instruction both show that IDCODE is restored. The instruction-capture pattern, the output-enable windows and the unchanged `tdo` after each rising edge separate correct timing from designs that capture or drive on the wrong edge.

// File: rtl/tap_pkg.sv
package tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_DR_SELECT,
        ST_DR_CAPTURE,
        ST_DR_SHIFT,
        ST_DR_EXIT1,
        ST_DR_PAUSE,
        ST_DR_EXIT2,
        ST_DR_UPDATE,
        ST_IR_SELECT,
        ST_IR_CAPTURE,
        ST_IR_SHIFT,
        ST_IR_EXIT1,
        ST_IR_PAUSE,
        ST_IR_EXIT2,
        ST_IR_UPDATE
    } tap_state_e;

    localparam int IR_W = 5;

    localparam logic [IR_W-1:0] OP_BND_DRIVE  = 5'b00000;
    localparam logic [IR_W-1:0] OP_BND_SAMPLE = 5'b00001;
    localparam logic [IR_W-1:0] OP_USER1      = 5'b00010;
    localparam logic [IR_W-1:0] OP_USER2      = 5'b00011;
    localparam logic [IR_W-1:0] OP_CFG_RD     = 5'b00100;
    localparam logic [IR_W-1:0] OP_CFG_WR     = 5'b00101;
    localparam logic [IR_W-1:0] OP_PINS_OFF   = 5'b00111;
    localparam logic [IR_W-1:0] OP_IDCODE     = 5'b01001;
    localparam logic [IR_W-1:0] OP_BYPASS     = 5'b11111;

    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 5'b00001;

    localparam int N_PORTS  = 5;
    localparam int PORT_BND = 0;
    localparam int PORT_U1  = 1;
    localparam int PORT_U2  = 2;
    localparam int PORT_RD  = 3;
    localparam int PORT_WR  = 4;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       in_reset,
    output logic       dr_capture,
    output logic       dr_shift,
    output logic       dr_update,
    output logic       ir_capture,
    output logic       ir_shift,
    output logic       ir_update
);

    tap_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET:      nxt = tms ? ST_RESET     : ST_IDLE;
            ST_IDLE:       nxt = tms ? ST_DR_SELECT : ST_IDLE;
            ST_DR_SELECT:  nxt = tms ? ST_IR_SELECT : ST_DR_CAPTURE;
            ST_DR_CAPTURE: nxt = tms ? ST_DR_EXIT1  : ST_DR_SHIFT;
            ST_DR_SHIFT:   nxt = tms ? ST_DR_EXIT1  : ST_DR_SHIFT;
            ST_DR_EXIT1:   nxt = tms ? ST_DR_UPDATE : ST_DR_PAUSE;
            ST_DR_PAUSE:   nxt = tms ? ST_DR_EXIT2  : ST_DR_PAUSE;
            ST_DR_EXIT2:   nxt = tms ? ST_DR_UPDATE : ST_DR_SHIFT;
            ST_DR_UPDATE:  nxt = tms ? ST_DR_SELECT : ST_IDLE;
            ST_IR_SELECT:  nxt = tms ? ST_RESET     : ST_IR_CAPTURE;
            ST_IR_CAPTURE: nxt = tms ? ST_IR_EXIT1  : ST_IR_SHIFT;
            ST_IR_SHIFT:   nxt = tms ? ST_IR_EXIT1  : ST_IR_SHIFT;
            ST_IR_EXIT1:   nxt = tms ? ST_IR_UPDATE : ST_IR_PAUSE;
            ST_IR_PAUSE:   nxt = tms ? ST_IR_EXIT2  : ST_IR_PAUSE;
            ST_IR_EXIT2:   nxt = tms ? ST_IR_UPDATE : ST_IR_SHIFT;
            ST_IR_UPDATE:  nxt = tms ? ST_DR_SELECT : ST_IDLE;
            default:       nxt = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

    always_comb begin
        in_reset   = 1'b0;
        dr_capture = 1'b0;
        dr_shift   = 1'b0;
        dr_update  = 1'b0;
        ir_capture = 1'b0;
        ir_shift   = 1'b0;
        ir_update  = 1'b0;
        unique case (state)
            ST_RESET:      in_reset   = 1'b1;
            ST_DR_CAPTURE: dr_capture = 1'b1;
            ST_DR_SHIFT:   dr_shift   = 1'b1;
            ST_DR_UPDATE:  dr_update  = 1'b1;
            ST_IR_CAPTURE: ir_capture = 1'b1;
            ST_IR_SHIFT:   ir_shift   = 1'b1;
            ST_IR_UPDATE:  ir_update  = 1'b1;
            default:       ;
        endcase
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            in_reset,
    input  logic            ir_capture,
    input  logic            ir_shift,
    input  logic            ir_update,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_shreg,
    output logic [IR_W-1:0] ir_q
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_shreg <= '0;
        end else if (ir_capture) begin
            ir_shreg <= IR_CAPTURE_PAT;
        end else if (ir_shift) begin
            ir_shreg <= {tdi, ir_shreg[IR_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_q <= OP_IDCODE;
        end else if (in_reset) begin
            ir_q <= OP_IDCODE;
        end else if (ir_update) begin
            ir_q <= ir_shreg;
        end
    end

endmodule

// File: rtl/tap_decode.sv
module tap_decode
    import tap_pkg::*;
(
    input  logic [IR_W-1:0]    ir_q,
    output logic               sel_id,
    output logic               sel_bypass,
    output logic [N_PORTS-1:0] port_sel,
    output logic               bsr_drive,
    output logic               highz
);

    always_comb begin
        sel_id     = 1'b0;
        sel_bypass = 1'b0;
        port_sel   = '0;
        bsr_drive  = 1'b0;
        highz      = 1'b0;
        case (ir_q)
            OP_BND_DRIVE: begin
                port_sel[PORT_BND] = 1'b1;
                bsr_drive          = 1'b1;
            end
            OP_BND_SAMPLE: port_sel[PORT_BND] = 1'b1;
            OP_USER1:      port_sel[PORT_U1]  = 1'b1;
            OP_USER2:      port_sel[PORT_U2]  = 1'b1;
            OP_CFG_RD:     port_sel[PORT_RD]  = 1'b1;
            OP_CFG_WR:     port_sel[PORT_WR]  = 1'b1;
            OP_IDCODE:     sel_id             = 1'b1;
            OP_PINS_OFF: begin
                highz      = 1'b1;
                sel_bypass = 1'b1;
            end
            default:       sel_bypass = 1'b1;
        endcase
    end

endmodule

// File: rtl/tap_dr.sv
module tap_dr #(
    parameter int          ID_W    = 32,
    parameter logic [31:0] ID_CODE = 32'h1A5C_E093
) (
    input  logic tck,
    input  logic trst_n,
    input  logic dr_capture,
    input  logic dr_shift,
    input  logic sel_id,
    input  logic sel_bypass,
    input  logic tdi,
    output logic bypass_q,
    output logic id_lsb
);

    localparam logic [ID_W-1:0] ID_VAL = ID_W'(ID_CODE);

    logic [ID_W-1:0] id_sr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            bypass_q <= 1'b0;
        end else if (sel_bypass && dr_capture) begin
            bypass_q <= 1'b0;
        end else if (sel_bypass && dr_shift) begin
            bypass_q <= tdi;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            id_sr <= '0;
        end else if (sel_id && dr_capture) begin
            id_sr <= ID_VAL;
        end else if (sel_id && dr_shift) begin
            id_sr <= {tdi, id_sr[ID_W-1:1]};
        end
    end

    assign id_lsb = id_sr[0];

endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
    import tap_pkg::*;
#(
    parameter int          ID_W    = 32,
    parameter logic [31:0] ID_CODE = 32'h1A5C_E093
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_oe,
    output logic               scan_si,
    input  logic [N_PORTS-1:0] ext_tdo,
    output logic [N_PORTS-1:0] ext_capture,
    output logic [N_PORTS-1:0] ext_shift,
    output logic [N_PORTS-1:0] ext_update,
    output logic               bsr_drive,
    output logic               highz
);

    tap_state_e         state;
    logic               in_reset, dr_capture, dr_shift, dr_update;
    logic               ir_capture, ir_shift, ir_update;
    logic [IR_W-1:0]    ir_shreg, ir_q;
    logic               sel_id, sel_bypass;
    logic [N_PORTS-1:0] port_sel;
    logic               bypass_q, id_lsb;
    logic               dout;

    tap_fsm u_fsm (
        .tck        (tck),
        .trst_n     (trst_n),
        .tms        (tms),
        .state      (state),
        .in_reset   (in_reset),
        .dr_capture (dr_capture),
        .dr_shift   (dr_shift),
        .dr_update  (dr_update),
        .ir_capture (ir_capture),
        .ir_shift   (ir_shift),
        .ir_update  (ir_update)
    );

    tap_ir u_ir (
        .tck        (tck),
        .trst_n     (trst_n),
        .in_reset   (in_reset),
        .ir_capture (ir_capture),
        .ir_shift   (ir_shift),
        .ir_update  (ir_update),
        .tdi        (tdi),
        .ir_shreg   (ir_shreg),
        .ir_q       (ir_q)
    );

    tap_decode u_dec (
        .ir_q       (ir_q),
        .sel_id     (sel_id),
        .sel_bypass (sel_bypass),
        .port_sel   (port_sel),
        .bsr_drive  (bsr_drive),
        .highz      (highz)
    );

    tap_dr #(
        .ID_W    (ID_W),
        .ID_CODE (ID_CODE)
    ) u_dr (
        .tck        (tck),
        .trst_n     (trst_n),
        .dr_capture (dr_capture),
        .dr_shift   (dr_shift),
        .sel_id     (sel_id),
        .sel_bypass (sel_bypass),
        .tdi        (tdi),
        .bypass_q   (bypass_q),
        .id_lsb     (id_lsb)
    );

    generate
        for (genvar p = 0; p < N_PORTS; p++) begin : g_port
            assign ext_capture[p] = dr_capture & port_sel[p];
            assign ext_shift[p]   = dr_shift   & port_sel[p];
            assign ext_update[p]  = dr_update  & port_sel[p];
        end
    endgenerate

    assign scan_si = tdi;

    always_comb begin
        if (ir_shift)        dout = ir_shreg[0];
        else if (sel_id)     dout = id_lsb;
        else if (|port_sel)  dout = |(ext_tdo & port_sel);
        else                 dout = bypass_q;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= dout;
            tdo_oe <= dr_shift | ir_shift;
        end
    end

endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
    import tap_pkg::*;
(
    input logic               tck,
    input logic               trst_n,
    input logic               tms,
    input tap_state_e         state,
    input logic [IR_W-1:0]    ir_q,
    input logic [IR_W-1:0]    ir_shreg,
    input logic [N_PORTS-1:0] ext_capture,
    input logic [N_PORTS-1:0] ext_shift,
    input logic [N_PORTS-1:0] ext_update,
    input logic               bsr_drive,
    input logic               highz,
    input logic               tdo_oe
);

    logic [2:0] ones_run;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)              ones_run <= '0;
        else if (!tms)            ones_run <= '0;
        else if (ones_run < 3'd5) ones_run <= ones_run + 3'd1;
    end

    p_five_ones_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_run == 3'd5) |-> (state == ST_RESET));

    p_reset_loads_id_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET) |=> (ir_q == OP_IDCODE));

    p_capture_pattern_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_IR_CAPTURE) |=> (ir_shreg[1:0] == 2'b01));

    p_ir_held_r5: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_IR_UPDATE && state != ST_RESET) |=> $stable(ir_q));

    p_one_port_r7: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0(ext_capture) && $onehot0(ext_shift) && $onehot0(ext_update));

    p_update_state_r7: assert property (@(posedge tck) disable iff (!trst_n)
        (|ext_update) |-> (state == ST_DR_UPDATE));

    p_drive_vs_off_r8: assert property (@(posedge tck) disable iff (!trst_n)
        highz |-> !bsr_drive);

    p_oe_window_r9: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == ST_DR_SHIFT || state == ST_IR_SHIFT));

endmodule

bind tap_ctrl tap_ctrl_chk u_chk (
    .tck         (tck),
    .trst_n      (trst_n),
    .tms         (tms),
    .state       (state),
    .ir_q        (ir_q),
    .ir_shreg    (ir_shreg),
    .ext_capture (ext_capture),
    .ext_shift   (ext_shift),
    .ext_update  (ext_update),
    .bsr_drive   (bsr_drive),
    .highz       (highz),
    .tdo_oe      (tdo_oe)
);

// File: tb/tb_tap_ctrl.sv
module tb_tap_ctrl;
    import tap_pkg::*;

    localparam logic [31:0] ID = 32'h1A5C_E093;

    logic               tck = 1'b0;
    logic               trst_n = 1'b0;
    logic               tms = 1'b1;
    logic               tdi = 1'b0;
    logic               tdo, tdo_oe, scan_si, bsr_drive, highz;
    logic [N_PORTS-1:0] ext_tdo = 5'b01101;
    logic [N_PORTS-1:0] ext_capture, ext_shift, ext_update;

    int errors = 0;
    int checks = 0;
    int edge_slip = 0;
    int oe_gap = 0;
    int cap_cnt [N_PORTS];
    int shf_cnt [N_PORTS];
    int upd_cnt [N_PORTS];

    always #5 tck = ~tck;

    tap_ctrl #(.ID_W(32), .ID_CODE(ID)) dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .tdo_oe(tdo_oe), .scan_si(scan_si), .ext_tdo(ext_tdo),
        .ext_capture(ext_capture), .ext_shift(ext_shift),
        .ext_update(ext_update), .bsr_drive(bsr_drive), .highz(highz)
    );

    always @(negedge tck) begin
        if (trst_n) begin
            for (int p = 0; p < N_PORTS; p++) begin
                cap_cnt[p] += int'(ext_capture[p]);
                shf_cnt[p] += int'(ext_shift[p]);
                upd_cnt[p] += int'(ext_update[p]);
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        for (int p = 0; p < N_PORTS; p++) begin
            cap_cnt[p] = 0; shf_cnt[p] = 0; upd_cnt[p] = 0;
        end
    endtask

    // one test clock: sample tdo after the falling edge, drive, then pass the rising edge
    task automatic step(input logic m, input logic d, output logic o, output logic oe);
        @(negedge tck); #1;
        o = tdo; oe = tdo_oe;
        tms = m; tdi = d;
        @(posedge tck); #1;
        if (tdo !== o) edge_slip++;
    endtask

    task automatic go(input logic m);
        logic o, oe;
        step(m, 1'b0, o, oe);
    endtask

    task automatic scan_ir(input logic [4:0] op, output logic [4:0] cap);
        logic oe;
        go(1); go(1); go(0); go(0);
        for (int i = 0; i < 5; i++) begin
            step(i == 4, op[i], cap[i], oe);
            if (!oe) oe_gap++;
        end
        go(1); go(0);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic oe;
        dout = '0;
        go(1); go(0); go(0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], dout[i], oe);
            if (!oe) oe_gap++;
        end
        go(1); go(0);
    endtask

    function automatic int port_of(input logic [4:0] op);
        case (op)
            5'b00000, 5'b00001: return 0;
            5'b00010:           return 1;
            5'b00011:           return 2;
            5'b00100:           return 3;
            5'b00101:           return 4;
            default:            return -1;
        endcase
    endfunction

    initial begin : watchdog
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [4:0]  cap;
        logic [63:0] out;
        logic        o, oe;

        repeat (3) @(negedge tck);
        // R1 reset state
        check(tdo_oe == 1'b0 && ext_capture == '0 && ext_shift == '0 && ext_update == '0,
              "R1 reset outputs", {tdo_oe, ext_capture, ext_shift, ext_update}, 0);
        check(bsr_drive == 1'b0 && highz == 1'b0, "R8 reset pins", {bsr_drive, highz}, 0);
        trst_n = 1'b1;
        go(0);
        step(0, 0, o, oe);
        check(oe == 1'b0, "R9 no drive in IDLE", oe, 0);

        // R3 identifier after reset
        clear_counts();
        scan_dr(32, 64'h0, out);
        check(out[31:0] == ID, "R3 idcode after reset", out[31:0], ID);

        // R4 instruction capture pattern
        scan_ir(OP_BYPASS, cap);
        check(cap == 5'b00001, "R4 IR capture", cap, 5'b00001);

        // R6 bypass delay
        scan_dr(8, 64'hB5, out);
        check(out[7:0] == 8'h6A, "R6 bypass delay", out[7:0], 8'h6A);

        // R5/R7/R8 sweep of all opcodes
        for (int op = 0; op < 32; op++) begin
            logic [4:0] opc;
            logic [3:0] exp;
            int pt;
            int bad;
            opc = 5'(op);
            pt  = port_of(opc);
            scan_ir(opc, cap);
            clear_counts();
            scan_dr(4, 64'hA, out);
            if (opc == OP_IDCODE)  exp = ID[3:0];
            else if (pt >= 0)      exp = {4{ext_tdo[pt]}};
            else                   exp = 4'h4;
            check(out[3:0] == exp, $sformatf("R5 opcode %05b data", opc), out[3:0], exp);
            bad = 0;
            for (int p = 0; p < N_PORTS; p++) begin
                if (p == pt) begin
                    if (cap_cnt[p] != 1 || shf_cnt[p] != 4 || upd_cnt[p] != 1) bad++;
                end else begin
                    if (cap_cnt[p] != 0 || shf_cnt[p] != 0 || upd_cnt[p] != 0) bad++;
                end
            end
            check(bad == 0, $sformatf("R7 opcode %05b strobes", opc), bad, 0);
            check(bsr_drive == (opc == OP_BND_DRIVE) && highz == (opc == OP_PINS_OFF),
                  $sformatf("R8 opcode %05b pin controls", opc), {bsr_drive, highz},
                  {(opc == OP_BND_DRIVE), (opc == OP_PINS_OFF)});
        end

        // R2 pause detour inside an identifier scan
        scan_ir(OP_IDCODE, cap);
        out = '0;
        go(1); go(0); go(0);
        for (int i = 0; i < 16; i++) step(i == 15, 1'b0, out[i], oe);
        go(0); go(0); go(1); go(0);
        for (int i = 16; i < 32; i++) step(i == 31, 1'b0, out[i], oe);
        go(1); go(0);
        check(out[31:0] == ID, "R2 pause keeps data", out[31:0], ID);

        // R1 five ones from DR_SHIFT under USER1
        scan_ir(OP_USER1, cap);
        go(1); go(0); go(0);
        go(1); go(1); go(1); go(1); go(1);
        go(0);
        scan_dr(32, 64'h0, out);
        check(out[31:0] == ID, "R1 five ones reach reset", out[31:0], ID);

        // R1 asynchronous reset mid instruction
        scan_ir(OP_USER2, cap);
        @(negedge tck); #2; trst_n = 1'b0; tms = 1'b0;
        @(negedge tck); #2; trst_n = 1'b1;
        go(0);
        scan_dr(32, 64'h0, out);
        check(out[31:0] == ID, "R1 async reset restores idcode", out[31:0], ID);

        // R9 timing summaries
        check(edge_slip == 0, "R9 tdo stable on rising edge", edge_slip, 0);
        check(oe_gap == 0, "R9 tdo_oe high in shift", oe_gap, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule